// File: doc/BRIEF.md
# Virtual-Channel Router Input Unit

This block is one input port of an on-chip network router. Flits arrive from the upstream link with a traffic-class bit, a channel select within that class, and head/tail markers. The unit files each flit into its own virtual-channel queue. Requests and replies travel in separate classes, and each class has two channels, which gives four queues per port. Every queue is deep enough for a complete five-flit message, so wormhole traffic with credit-based flow control can never leave a message straddling a blocked queue.

Each queue presents its oldest flit, with its flags, to the allocation stages. The unit also shows a per-queue state (idle, waiting for a downstream channel, or active) and the number of free slots. When the switch pulls a flit from a queue, the unit sends one credit pulse upstream in that same cycle, tagged with the queue index. The upstream counter therefore learns of the freed slot after one cycle on the wire.

Top module: `vc_input_unit`

## Requirements
- R1: After reset every queue is empty (`headValid` low), every `vcState` field is idle (encoding 0), every `freeSlots` field equals the depth (5), and `creditValid` is low.
- R2: A flit written with class `inVnet` (0 = request, 1 = reply) and select `inVcSel` lands in queue index `inVnet*2 + inVcSel`. A request never appears in queues 2 or 3, and a reply never appears in queues 0 or 1.
- R3: Each queue is first-in first-out. Its oldest flit appears on `headData`, `headIsHead` and `headIsTail` in the cycle after it is written, and the next one appears in the cycle after a dequeue.
- R4: `freeSlots` of a queue drops by one for each flit accepted and rises by one for each flit dequeued. It stays unchanged when both happen in the same cycle, and it reaches 0 after five flits with no dequeue.
- R5: In any cycle where `deqStrobe` selects a non-empty queue, `creditValid` is high in that same cycle and `creditVc` holds that queue's index. In all other cycles `creditValid` is low.
- R6: A dequeue strobe aimed at an empty queue produces no credit and changes no queue's state, free count or front flit.
- R7: `vcState` uses 2-bit fields: 0 idle, 1 waiting for a channel, 2 active. A head flit written to an idle queue moves it to 1. Dequeuing a non-tail flit moves it to 2. Dequeuing a tail moves it to 0 if the queue is then empty, and to 1 otherwise.
- R8: A write to a full queue is legal only when the same queue is dequeued in that cycle, and it is then accepted with the free count held at 0. Writing a full queue without a dequeue is a protocol error.
- R9: Queues are independent. Writes and dequeues on one queue leave the contents, state and free count of every other queue unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Incoming flit valid |
| inVnet | input | 1 | Traffic class: 0 request, 1 reply |
| inVcSel | input | 1 | Channel select within the class |
| inHead | input | 1 | Flit is the first of its message |
| inTail | input | 1 | Flit is the last of its message |
| inData | input | 128 | Flit payload |
| deqStrobe | input | 4 | One-hot-or-zero dequeue request from the switch |
| headValid | output | 4 | Queue holds at least one flit |
| headIsHead | output | 4 | Front flit head marker, per queue |
| headIsTail | output | 4 | Front flit tail marker, per queue |
| headData | output | 512 | Front flit payload, queue v in bits [v*128 +: 128] |
| vcState | output | 8 | Queue state, 2 bits per queue |
| freeSlots | output | 12 | Free slots, 3 bits per queue |
| creditValid | output | 1 | Credit pulse to upstream |
| creditVc | output | 2 | Queue index the credit belongs to |

## Verification
The bench builds the unit with a 16-bit flit and keeps the default two classes, two channels per class and five-slot queues. The narrow payload lets every stored flit carry a unique tag, so any misfiling or reordering shows up. The small queue count allows every class/select pair to be swept directly and every queue to be filled to exactly five and drained. Routing a write into a full queue during a dequeue, and issuing strobes at empty queues, then cover the boundaries. A long pseudo-random run of mixed writes and dequeues checks the state rules and queue independence against an arithmetic model.

// File: rtl/vcu_pkg.sv
package vcu_pkg;

  typedef enum logic [1:0] {
    VC_IDLE   = 2'd0,
    VC_WAIT   = 2'd1,
    VC_ACTIVE = 2'd2
  } vcState_e;

  typedef struct packed {
    logic push;
    logic pop;
  } vcStrobe_t;

endpackage

// File: rtl/vcu_ctrl.sv
module vcu_ctrl
  import vcu_pkg::*;
#(
  parameter int DEPTH = 5,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrReq,
  input  logic             deqReq,
  input  logic             inHead,
  input  logic             frontTail,
  output vcStrobe_t        strobe,
  output vcState_e         state,
  output logic [CNT_W-1:0] count
);

  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  logic [CNT_W-1:0] countNext;
  vcState_e         stateNext;

  always_comb begin
    strobe.pop  = deqReq && (count != '0);
    strobe.push = wrReq && ((count != FULL) || strobe.pop);
  end

  always_comb begin
    countNext = count;
    if (strobe.push && !strobe.pop) countNext = count + 1'b1;
    if (strobe.pop && !strobe.push) countNext = count - 1'b1;
  end

  always_comb begin
    stateNext = state;
    if (strobe.pop) begin
      if (frontTail) stateNext = (countNext != '0) ? VC_WAIT : VC_IDLE;
      else           stateNext = VC_ACTIVE;
    end else if (strobe.push && inHead && state == VC_IDLE) begin
      stateNext = VC_WAIT;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count <= '0;
      state <= VC_IDLE;
    end else begin
      count <= countNext;
      state <= stateNext;
    end
  end

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrReq && count == FULL) |-> deqReq);

  // R7
  tail_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (deqReq && frontTail && count == CNT_W'(1) && !wrReq) |=> state == VC_IDLE);

  // R6
  empty_deq_chk: assert property (@(posedge clk) disable iff (!rstN)
    (deqReq && count == '0 && !wrReq) |=> (count == '0 && $stable(state)));

endmodule

// File: rtl/vcu_data.sv
module vcu_data
  import vcu_pkg::*;
#(
  parameter int NUM_VC = 4,
  parameter int DEPTH  = 5,
  parameter int FLIT_W = 128,
  parameter int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  vcStrobe_t [NUM_VC-1:0]         strobes,
  input  logic                           wrHead,
  input  logic                           wrTail,
  input  logic [FLIT_W-1:0]              wrData,
  output logic [NUM_VC-1:0]              frontHead,
  output logic [NUM_VC-1:0]              frontTail,
  output logic [NUM_VC-1:0][FLIT_W-1:0]  frontData
);

  localparam int SLOT_W = FLIT_W + 2;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  for (genvar v = 0; v < NUM_VC; v++) begin : g_vc
    logic [SLOT_W-1:0] slots [DEPTH];
    logic [PTR_W-1:0]  wrPtr;
    logic [PTR_W-1:0]  rdPtr;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        wrPtr <= '0;
        rdPtr <= '0;
      end else begin
        if (strobes[v].push) wrPtr <= (wrPtr == LAST) ? '0 : wrPtr + 1'b1;
        if (strobes[v].pop)  rdPtr <= (rdPtr == LAST) ? '0 : rdPtr + 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (strobes[v].push) slots[wrPtr] <= {wrHead, wrTail, wrData};
    end

    assign frontHead[v] = slots[rdPtr][SLOT_W-1];
    assign frontTail[v] = slots[rdPtr][SLOT_W-2];
    assign frontData[v] = slots[rdPtr][FLIT_W-1:0];

    // R3
    ptr_range_chk: assert property (@(posedge clk) disable iff (!rstN)
      (wrPtr <= LAST) && (rdPtr <= LAST));
  end

endmodule

// File: rtl/vc_input_unit.sv
module vc_input_unit
  import vcu_pkg::*;
#(
  parameter int NUM_VNET    = 2,
  parameter int VC_PER_VNET = 2,
  parameter int DEPTH       = 5,
  parameter int FLIT_W      = 128,
  localparam int NUM_VC     = NUM_VNET * VC_PER_VNET,
  localparam int VNET_W     = (NUM_VNET > 1) ? $clog2(NUM_VNET) : 1,
  localparam int SEL_W      = (VC_PER_VNET > 1) ? $clog2(VC_PER_VNET) : 1,
  localparam int VC_W       = (NUM_VC > 1) ? $clog2(NUM_VC) : 1,
  localparam int CNT_W      = $clog2(DEPTH + 1)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     inValid,
  input  logic [VNET_W-1:0]        inVnet,
  input  logic [SEL_W-1:0]         inVcSel,
  input  logic                     inHead,
  input  logic                     inTail,
  input  logic [FLIT_W-1:0]        inData,
  input  logic [NUM_VC-1:0]        deqStrobe,
  output logic [NUM_VC-1:0]        headValid,
  output logic [NUM_VC-1:0]        headIsHead,
  output logic [NUM_VC-1:0]        headIsTail,
  output logic [NUM_VC*FLIT_W-1:0] headData,
  output logic [NUM_VC*2-1:0]      vcState,
  output logic [NUM_VC*CNT_W-1:0]  freeSlots,
  output logic                     creditValid,
  output logic [VC_W-1:0]          creditVc
);

  logic [VC_W-1:0]                wrIdx;
  vcStrobe_t [NUM_VC-1:0]         strobes;
  vcState_e                       states [NUM_VC];
  logic [CNT_W-1:0]               counts [NUM_VC];
  logic [NUM_VC-1:0]              frontTail;
  logic [NUM_VC-1:0][FLIT_W-1:0]  frontData;

  assign wrIdx = VC_W'(int'(inVnet) * VC_PER_VNET + int'(inVcSel));

  for (genvar v = 0; v < NUM_VC; v++) begin : g_ctrl
    vcu_ctrl #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_ctrl (
      .clk      (clk),
      .rstN     (rstN),
      .wrReq    (inValid && (wrIdx == VC_W'(v))),
      .deqReq   (deqStrobe[v]),
      .inHead   (inHead),
      .frontTail(frontTail[v]),
      .strobe   (strobes[v]),
      .state    (states[v]),
      .count    (counts[v])
    );
    assign headValid[v]                   = (counts[v] != '0);
    assign vcState[2*v +: 2]              = states[v];
    assign freeSlots[v*CNT_W +: CNT_W]    = CNT_W'(DEPTH) - counts[v];
    assign headData[v*FLIT_W +: FLIT_W]   = frontData[v];
  end

  assign headIsTail = frontTail;

  vcu_data #(.NUM_VC(NUM_VC), .DEPTH(DEPTH), .FLIT_W(FLIT_W)) u_data (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .wrHead   (inHead),
    .wrTail   (inTail),
    .wrData   (inData),
    .frontHead(headIsHead),
    .frontTail(frontTail),
    .frontData(frontData)
  );

  always_comb begin
    creditValid = 1'b0;
    creditVc    = '0;
    for (int v = 0; v < NUM_VC; v++) begin
      if (strobes[v].pop) begin
        creditValid = 1'b1;
        creditVc    = VC_W'(v);
      end
    end
  end

  // R6
  one_deq_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(deqStrobe));

  // R2
  sel_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid |-> (int'(inVcSel) < VC_PER_VNET));

  // R5
  credit_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    creditValid |-> (deqStrobe[creditVc] && headValid[creditVc]));

endmodule

// File: tb/test_vc_input_unit.sv
`timescale 1ns/1ps
module test_vc_input_unit;

  localparam int FW = 16;
  localparam int NV = 4;
  localparam int DP = 5;

  logic          clk = 1'b0;
  logic          rstN;
  logic          inValid;
  logic [0:0]    inVnet;
  logic [0:0]    inVcSel;
  logic          inHead;
  logic          inTail;
  logic [FW-1:0] inData;
  logic [NV-1:0] deqStrobe;
  logic [NV-1:0] headValid, headIsHead, headIsTail;
  logic [NV*FW-1:0] headData;
  logic [NV*2-1:0]  vcState;
  logic [NV*3-1:0]  freeSlots;
  logic          creditValid;
  logic [1:0]    creditVc;

  vc_input_unit #(.FLIT_W(FW)) i_vc_input_unit (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inVnet(inVnet), .inVcSel(inVcSel),
    .inHead(inHead), .inTail(inTail), .inData(inData), .deqStrobe(deqStrobe),
    .headValid(headValid), .headIsHead(headIsHead), .headIsTail(headIsTail),
    .headData(headData), .vcState(vcState), .freeSlots(freeSlots),
    .creditValid(creditValid), .creditVc(creditVc)
  );

  always #4 clk = ~clk;

  int nChecks = 0;
  int nFails  = 0;

  // model: {head, tail, data}, index 0 is oldest
  logic [FW+1:0] mq [NV][DP];
  int mcnt [NV];
  int mst  [NV];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic checkAll(input string tag);
    for (int k = 0; k < NV; k++) begin
      chk(headValid[k] == (mcnt[k] > 0), {tag, " headValid"}, int'(headValid[k]), int'(mcnt[k] > 0));
      chk(int'(vcState[2*k +: 2]) == mst[k], {tag, " vcState"}, int'(vcState[2*k +: 2]), mst[k]);
      chk(int'(freeSlots[3*k +: 3]) == DP - mcnt[k], {tag, " freeSlots"},
          int'(freeSlots[3*k +: 3]), DP - mcnt[k]);
      if (mcnt[k] > 0) begin
        chk(headData[k*FW +: FW] == mq[k][0][FW-1:0], {tag, " headData"},
            int'(headData[k*FW +: FW]), int'(mq[k][0][FW-1:0]));
        chk(headIsHead[k] == mq[k][0][FW+1] && headIsTail[k] == mq[k][0][FW], {tag, " flags"},
            int'({headIsHead[k], headIsTail[k]}), int'(mq[k][0][FW+1:FW]));
      end
    end
  endtask

  // one cycle: drive at negedge, check credit before the edge, check state after it
  task automatic step(input bit v, input int vn, input int sel, input bit h, input bit t,
                      input logic [FW-1:0] d, input logic [NV-1:0] deq, input string tag);
    int idx;
    bit expV;
    int expVc;
    idx = vn * 2 + sel;
    inValid = v; inVnet = 1'(vn); inVcSel = 1'(sel); inHead = h; inTail = t;
    inData = d; deqStrobe = deq;
    expV = 1'b0; expVc = 0;
    for (int k = 0; k < NV; k++) if (deq[k] && mcnt[k] > 0) begin expV = 1'b1; expVc = k; end
    #1;
    chk(creditValid == expV, {tag, " R5 creditValid"}, int'(creditValid), int'(expV));
    if (expV) chk(int'(creditVc) == expVc, {tag, " R5 creditVc"}, int'(creditVc), expVc);
    for (int k = 0; k < NV; k++) begin
      bit pop, push, ptail;
      pop = deq[k] && mcnt[k] > 0;
      push = v && idx == k;
      ptail = pop && mq[k][0][FW];
      if (pop) begin
        for (int j = 0; j < DP - 1; j++) mq[k][j] = mq[k][j+1];
        mcnt[k]--;
      end
      if (push) begin mq[k][mcnt[k]] = {h, t, d}; mcnt[k]++; end
      if (pop) mst[k] = ptail ? ((mcnt[k] > 0) ? 1 : 0) : 2;
      else if (push && h && mst[k] == 0) mst[k] = 1;
    end
    @(posedge clk);
    #1;
    checkAll(tag);
    @(negedge clk);
  endtask

  initial begin
    #(8ns * 100000);
    nFails++;
    nChecks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    logic [31:0] lfsr;
    for (int k = 0; k < NV; k++) begin mcnt[k] = 0; mst[k] = 0; end
    rstN = 1'b0; inValid = 0; inVnet = 0; inVcSel = 0; inHead = 0; inTail = 0;
    inData = '0; deqStrobe = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    checkAll("R1 reset");
    chk(creditValid == 1'b0, "R1 credit", int'(creditValid), 0);
    @(negedge clk);

    // R2: sweep every class/select pair with a single-flit message
    for (int vn = 0; vn < 2; vn++)
      for (int sel = 0; sel < 2; sel++) begin
        step(1, vn, sel, 1, 1, 16'(16'hA000 + vn * 16 + sel), '0, "R2 sort");
        step(0, 0, 0, 0, 0, '0, 4'(1 << (vn * 2 + sel)), "R7 single drain");
      end

    // R4/R3: fill each queue with a full message, then overflow-with-dequeue, then drain
    for (int q = 0; q < NV; q++) begin
      for (int f = 0; f < DP; f++)
        step(1, q / 2, q % 2, f == 0, f == DP - 1, 16'(q * 256 + f), '0, "R4 fill");
      step(1, q / 2, q % 2, 1, 0, 16'(q * 256 + 99), 4'(1 << q), "R8 full write with dequeue");
      for (int f = 0; f < DP; f++)
        step(0, 0, 0, 0, 0, '0, 4'(1 << q), "R3 drain");
      step(0, 0, 0, 0, 0, '0, 4'(1 << q), "R6 empty dequeue");
      step(0, 0, 0, 0, 0, '0, 4'(1 << ((q + 1) % NV)), "R6 empty dequeue other");
    end

    // R9: mixed traffic across all queues
    lfsr = 32'h1234_5678;
    for (int n = 0; n < 400; n++) begin
      bit v, h, t;
      int vn, sel;
      logic [NV-1:0] deq;
      lfsr = lfsr * 32'd1664525 + 32'd1013904223;
      v = lfsr[16]; vn = int'(lfsr[17]); sel = int'(lfsr[18]);
      h = lfsr[19]; t = lfsr[20];
      deq = lfsr[23] ? 4'(1 << lfsr[22:21]) : '0;
      if (v && mcnt[vn * 2 + sel] == DP && !deq[vn * 2 + sel]) v = 1'b0;
      step(v, vn, sel, h, t, lfsr[31:16], deq, "R9 mixed");
    end

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule